// File: doc/BRIEF.md
# Multi-Context Interrupt Routing Controller

The block collects 32 level-sensitive interrupt inputs and steers each of them onto one of up to 15 parent interrupt lines. It does this separately for every processor context. Each context owns a bank with an enable mask and four routing words, so the same input can be delivered to one context, to several, or to none. Every input passes through a two-flop synchroniser. Each output line of a context is the registered OR of all inputs that are high, enabled in that context and routed to that line.

Software programs the banks through a simple word-addressed register port. The port has byte strobes and a context selector. A status word returns the synchronised level of every input, and every context sees the same status word.

Top module: `intr_route_top`

## Requirements
- R1: After reset every output line is low, and every enable word and routing word reads 0 in every context.
- R2: A routing value v from 1 to 15 sends the input to output line v-1 of that context while the input is high and enabled there.
- R3: The 4-bit routing field of input n sits in the word at byte offset 0x08 + 4*(3 - n/8), bits 4*(n mod 8)+3 down to 4*(n mod 8). Inputs 31..24 therefore share offset 0x08, and inputs 7..0 share offset 0x14.
- R4: An input whose enable bit (offset 0x00, bit n) is 0 drives no output in that context, whatever its routing field holds.
- R5: An input that is enabled but has routing field 0 never asserts any output line.
- R6: Each output line is the OR of all inputs routed to it. The line follows the input levels and falls once every such input is low.
- R7: Each context has its own enable and routing words. A write with context selector c changes only context c's outputs and read-back values.
- R8: Offset 0x04 reads the synchronised levels of the 32 inputs, with bit n holding input n. Writes to this offset change nothing.
- R9: A write updates only the bytes whose strobe bit is set. Strobe bit k covers data bits 8k+7..8k.
- R10: Offsets 0x18 and 0x1C read as 0, and writes to them change no register.
- R11: A change on an input reaches the outputs on the third rising edge after it is applied (two synchroniser edges and one output register). Read data appears on the edge that samples the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Level interrupt inputs |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ctx | input | CTX_W | Context bank selector |
| bus_addr | input | 5 | Byte offset in the bank |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | N_CTX*N_OUT | Output lines; line j of context c at bit c*N_OUT+j |

## Verification
The checker watches on every cycle for the following. A context whose enable word is all zero, or whose routing words are all zero, produces silent outputs one cycle later. A write to an undefined offset, or a write with no strobes set, leaves every bank unchanged. A status read returns the synchronised levels. The outputs hold still while the configuration and the inputs hold still. Only the bench's scenarios show the other behaviours: the exact nibble placement for particular inputs, the mapping of a routing value to a line, OR-combining with partial release, isolation between contexts, byte-strobe merging, and the three-edge input latency.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;
    localparam int REG_W   = 32;
    localparam int N_IN    = 32;
    localparam int SEL_W   = 4;
    localparam int N_ROUTE = 4;
    localparam int PER_REG = REG_W / SEL_W;
    localparam int ADDR_W  = 5;
    localparam int BE_W    = REG_W / 8;

    typedef enum logic [2:0] {
        W_ENABLE = 3'd0,
        W_STATUS = 3'd1,
        W_ROUTE0 = 3'd2,
        W_ROUTE1 = 3'd3,
        W_ROUTE2 = 3'd4,
        W_ROUTE3 = 3'd5
    } word_e;

    typedef struct packed {
        logic [REG_W-1:0]                en;
        logic [N_ROUTE-1:0][REG_W-1:0]   route;
    } bank_t;

    function automatic logic [REG_W-1:0] byte_merge(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic [BE_W-1:0]  be
    );
        logic [REG_W-1:0] r;
        r = old_v;
        for (int k = 0; k < BE_W; k++)
            if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
        return r;
    endfunction
endpackage

// File: rtl/intr_sync.sv
module intr_sync
    import intr_route_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] async_in,
    output logic [N_IN-1:0] sync_out
);
    logic [STAGES-1:0][N_IN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++)
            chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/intr_ctx_bank.sv
module intr_ctx_bank
    import intr_route_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [2:0]                    word,
    input  logic [REG_W-1:0]              wdata,
    input  logic [BE_W-1:0]               be,
    output logic [REG_W-1:0]              en_q,
    output logic [N_ROUTE-1:0][REG_W-1:0] route_q
);
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (word)
                W_ENABLE: bank_d.en = byte_merge(bank_q.en, wdata, be);
                W_ROUTE0: bank_d.route[0] = byte_merge(bank_q.route[0], wdata, be);
                W_ROUTE1: bank_d.route[1] = byte_merge(bank_q.route[1], wdata, be);
                W_ROUTE2: bank_d.route[2] = byte_merge(bank_q.route[2], wdata, be);
                W_ROUTE3: bank_d.route[3] = byte_merge(bank_q.route[3], wdata, be);
                default:  bank_d = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign en_q    = bank_q.en;
    assign route_q = bank_q.route;
endmodule

// File: rtl/intr_route_fabric.sv
module intr_route_fabric
    import intr_route_pkg::*;
#(
    parameter int N_OUT = 15
) (
    input  logic [N_IN-1:0]               lvl,
    input  logic [REG_W-1:0]              en,
    input  logic [N_ROUTE-1:0][REG_W-1:0] route,
    output logic [N_OUT-1:0]              lines
);
    logic [N_IN-1:0][SEL_W-1:0] sel;

    // inverted packing: highest inputs live in the first routing word
    for (genvar n = 0; n < N_IN; n++) begin : g_sel
        localparam int RIDX  = N_ROUTE - 1 - n / PER_REG;
        localparam int SHIFT = SEL_W * (n % PER_REG);
        assign sel[n] = route[RIDX][SHIFT +: SEL_W];
    end

    always_comb begin
        lines = '0;
        for (int j = 0; j < N_OUT; j++)
            for (int n = 0; n < N_IN; n++)
                if (lvl[n] && en[n] && sel[n] == SEL_W'(j + 1))
                    lines[j] = 1'b1;
    end
endmodule

// File: rtl/intr_route_top.sv
module intr_route_top
    import intr_route_pkg::*;
#(
    parameter int N_CTX       = 2,
    parameter int N_OUT       = 15,
    parameter int SYNC_STAGES = 2,
    localparam int CTX_W      = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        irq_in,
    input  logic                   bus_en,
    input  logic                   bus_wr,
    input  logic [CTX_W-1:0]       bus_ctx,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [REG_W-1:0]       bus_wdata,
    input  logic [BE_W-1:0]        bus_be,
    output logic [REG_W-1:0]       bus_rdata,
    output logic [N_CTX*N_OUT-1:0] irq_out
);
    typedef struct packed {
        logic [N_CTX*N_OUT-1:0] lines;
        logic [REG_W-1:0]       rdata;
    } top_t;

    logic [N_IN-1:0]                         sync_lvl;
    logic [N_CTX-1:0][REG_W-1:0]             en_all;
    logic [N_CTX-1:0][N_ROUTE-1:0][REG_W-1:0] route_all;
    logic [N_CTX*N_OUT-1:0]                  lines_c;
    logic [2:0]                              word;
    top_t st_d, st_q;

    assign word = bus_addr[ADDR_W-1:2];

    intr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(sync_lvl)
    );

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        logic wr_hit;
        assign wr_hit = bus_en && bus_wr && (bus_ctx == CTX_W'(c));

        intr_ctx_bank u_bank (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .word(word),
            .wdata(bus_wdata), .be(bus_be),
            .en_q(en_all[c]), .route_q(route_all[c])
        );

        intr_route_fabric #(.N_OUT(N_OUT)) u_fabric (
            .lvl(sync_lvl), .en(en_all[c]), .route(route_all[c]),
            .lines(lines_c[c*N_OUT +: N_OUT])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.lines = lines_c;
        if (bus_en && !bus_wr) begin
            st_d.rdata = '0;
            for (int c = 0; c < N_CTX; c++) begin
                if (bus_ctx == CTX_W'(c)) begin
                    case (word)
                        W_ENABLE: st_d.rdata = en_all[c];
                        W_STATUS: st_d.rdata = sync_lvl;
                        W_ROUTE0: st_d.rdata = route_all[c][0];
                        W_ROUTE1: st_d.rdata = route_all[c][1];
                        W_ROUTE2: st_d.rdata = route_all[c][2];
                        W_ROUTE3: st_d.rdata = route_all[c][3];
                        default:  st_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out   = st_q.lines;
    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/intr_route_chk.sv
module intr_route_chk
    import intr_route_pkg::*;
#(
    parameter int N_CTX = 2,
    parameter int N_OUT = 15,
    parameter int CTX_W = 1
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    bus_en,
    input logic                                    bus_wr,
    input logic [CTX_W-1:0]                        bus_ctx,
    input logic [ADDR_W-1:0]                       bus_addr,
    input logic [BE_W-1:0]                         bus_be,
    input logic [REG_W-1:0]                        bus_rdata,
    input logic [N_CTX*N_OUT-1:0]                  irq_out,
    input logic [N_IN-1:0]                         sync_lvl,
    input logic [N_CTX-1:0][REG_W-1:0]             en_all,
    input logic [N_CTX-1:0][N_ROUTE-1:0][REG_W-1:0] route_all
);
    for (genvar c = 0; c < N_CTX; c++) begin : g_c
        assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[c] == '0) |=> (irq_out[c*N_OUT +: N_OUT] == '0));
        assert_unrouted_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (route_all[c] == '0) |=> (irq_out[c*N_OUT +: N_OUT] == '0));
    end

    assert_undef_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr[ADDR_W-1:2] >= 3'd6)
        |=> ($stable(en_all) && $stable(route_all)));

    assert_no_strobe_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_be == '0) |=> ($stable(en_all) && $stable(route_all)));

    assert_status_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && bus_addr[ADDR_W-1:2] == 3'd1) |=> (bus_rdata == $past(sync_lvl)));

    assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(en_all) && $stable(route_all) && $stable(sync_lvl)) |=> $stable(irq_out));
endmodule

bind intr_route_top intr_route_chk #(.N_CTX(N_CTX), .N_OUT(N_OUT), .CTX_W(CTX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_ctx(bus_ctx),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .sync_lvl(sync_lvl), .en_all(en_all), .route_all(route_all)
);

// File: tb/intr_route_top_bench.sv
module intr_route_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int NO = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [0:0]  bus_ctx = '0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [NC*NO-1:0] irq_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_route_top u_intr_route_top (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_ctx(bus_ctx), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    typedef struct {
        string       tag;
        bit          is_rd;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];
    int    outstanding = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    logic [31:0] m_en [NC];
    logic [31:0] m_rt [NC][4];

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sb.size() != 0);
            it = sb.pop_front();
            act = it.is_rd ? bus_rdata : 32'(irq_out);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
            outstanding--;
        end
    end

    task automatic push(string tag, bit is_rd, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.is_rd = is_rd; it.exp = exp;
        outstanding++;
        sb.push_back(it);
        wait (outstanding == 0);
    endtask

    function automatic logic [31:0] model();
        logic [31:0] r = '0;
        for (int c = 0; c < NC; c++)
            for (int n = 0; n < 32; n++) begin
                logic [3:0] v = m_rt[c][3 - n/8][4*(n%8) +: 4];
                if (m_en[c][n] && irq_in[n] && v != 0) r[c*NO + int'(v) - 1] = 1'b1;
            end
        return r;
    endfunction

    task automatic step(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(int c, logic [4:0] a, logic [31:0] d, logic [3:0] be);
        bus_en = 1; bus_wr = 1; bus_ctx = 1'(c); bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); @(negedge clk);
        bus_en = 0; bus_wr = 0;
        if (a == 5'h00 || (a >= 5'h08 && a <= 5'h14)) begin
            for (int k = 0; k < 4; k++)
                if (be[k]) begin
                    if (a == 5'h00) m_en[c][8*k +: 8] = d[8*k +: 8];
                    else m_rt[c][(a - 5'h08) >> 2][8*k +: 8] = d[8*k +: 8];
                end
        end
    endtask

    task automatic rd_chk(int c, logic [4:0] a, logic [31:0] exp, string tag);
        bus_en = 1; bus_wr = 0; bus_ctx = 1'(c); bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_en = 0;
        push(tag, 1'b1, exp);
    endtask

    task automatic set_route(int c, int n, logic [3:0] v);
        logic [31:0] w = m_rt[c][3 - n/8];
        w[4*(n%8) +: 4] = v;
        wr(c, 5'(8 + 4*(3 - n/8)), w, 4'hf);
    endtask

    task automatic settle(string tag);
        step(3);
        push(tag, 1'b0, model());
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_en[c] = '0;
            for (int k = 0; k < 4; k++) m_rt[c][k] = '0;
        end
        step(2);
        rst_n = 1;
        step(1);
        // reset state
        push("R1 outputs after reset", 1'b0, 32'h0);
        rd_chk(0, 5'h00, 32'h0, "R1 ctx0 enable reset");
        rd_chk(1, 5'h08, 32'h0, "R1 ctx1 route word reset");

        // routing value 1 -> line 0 with latency check
        wr(0, 5'h00, 32'h0000_0001, 4'hf);
        set_route(0, 0, 4'd1);
        begin
            logic [31:0] old_v = model();
            irq_in[0] = 1'b1;
            step(2);
            push("R11 output unchanged after two edges", 1'b0, old_v);
            step(1);
            push("R11 R2 line0 asserted on third edge", 1'b0, model());
        end

        // input 31, value 15 -> line 14; placement in first routing word
        wr(0, 5'h00, 32'h8000_0001, 4'hf);
        set_route(0, 31, 4'd15);
        irq_in[31] = 1'b1;
        settle("R2 input31 to line14");
        rd_chk(0, 5'h08, 32'hF000_0000, "R3 input31 nibble at 0x08 top");

        // input 9, value 5 -> line 4, word at 0x10 bits 7:4
        wr(0, 5'h00, 32'h8000_0201, 4'hf);
        set_route(0, 9, 4'd5);
        irq_in[9] = 1'b1;
        settle("R2 input9 to line4");
        rd_chk(0, 5'h10, 32'h0000_0050, "R3 input9 nibble at 0x10");

        // enable cleared suppresses
        wr(0, 5'h00, 32'h0000_0201, 4'hf);
        settle("R4 input31 disabled");

        // enabled but unrouted
        wr(0, 5'h00, 32'h0000_0221, 4'hf);
        irq_in[5] = 1'b1;
        settle("R5 input5 enabled route0 silent");

        // OR of two inputs on line 0
        wr(0, 5'h00, 32'h0000_0223, 4'hf);
        set_route(0, 1, 4'd1);
        irq_in[1] = 1'b1;
        settle("R6 two inputs on line0");
        irq_in[0] = 1'b0;
        settle("R6 line0 held by input1");
        irq_in[1] = 1'b0;
        settle("R6 line0 released");

        // second context independent
        wr(1, 5'h00, 32'h0000_0200, 4'hf);
        set_route(1, 9, 4'd3);
        settle("R7 ctx1 line2 from input9, ctx0 unchanged");
        rd_chk(0, 5'h10, 32'h0000_0050, "R7 ctx0 route word untouched");

        // status read-only
        rd_chk(0, 5'h04, irq_in, "R8 status levels");
        wr(1, 5'h04, 32'hFFFF_FFFF, 4'hf);
        rd_chk(1, 5'h04, irq_in, "R8 status after write");
        settle("R8 outputs after status write");

        // byte strobes
        wr(1, 5'h00, 32'hFFFF_FFA5, 4'b0001);
        rd_chk(1, 5'h00, m_en[1], "R9 only low byte written");
        settle("R9 outputs after partial write");

        // undefined offsets
        wr(0, 5'h18, 32'hFFFF_FFFF, 4'hf);
        wr(1, 5'h1C, 32'hFFFF_FFFF, 4'hf);
        rd_chk(0, 5'h18, 32'h0, "R10 offset 0x18 reads 0");
        rd_chk(1, 5'h1C, 32'h0, "R10 offset 0x1C reads 0");
        rd_chk(0, 5'h00, m_en[0], "R10 ctx0 enable intact");
        rd_chk(1, 5'h10, m_rt[1][2], "R10 ctx1 route intact");
        settle("R10 outputs intact");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule